// File: doc/BRIEF.md
# Programmable Dual-Bank Lane Lookup

This block is a SIMD table-lookup unit with `LANES` byte lanes and two byte tables of 256 entries each, called bank A and bank B. Both tables are plain storage that is filled at run time, so any function of one byte can be evaluated on every lane at once. Examples are an exponent, a reciprocal or an activation curve.

A 3-bit function code, qualified by `op_valid`, chooses between lookup and load. Bit 0 of the code selects the bank for both.

- A lookup uses each input byte lane as an unsigned address into the chosen bank. It returns the stored bytes on a registered output one cycle later.
- A load copies one wide register (`LANES` words of 32 bits) into one aligned segment of the chosen bank. A load leaves the output alone.
- Reserved codes and out-of-range segment indices are refused. They raise a registered illegal flag.

Top module: `dual_bank_lane_lut`

## Requirements
- R1: After reset, `out_lanes` is all zero and `illegal` is 0.
- R2: With `op_valid`=1 and `fn`=3'b000, every output lane i equals bank A at the address given by the unsigned value of input byte lane i. The result appears on the first clock edge after the request, and `illegal` is 0.
- R3: `fn`=3'b001 performs the same lookup from bank B. Loads into one bank never change the other bank.
- R4: With `op_valid`=1, `fn`=3'b100 (bank A) or 3'b101 (bank B) and segment index s < 256/(LANES*4), entries s*LANES*4 through (s+1)*LANES*4-1 are written. Word lane j supplies entries base+4j through base+4j+3, least significant byte at the lowest address. This means entry base+b takes bits [8b+7:8b] of `word_lanes`.
- R5: A load leaves `out_lanes` unchanged and keeps `illegal` at 0 when the segment is in range.
- R6: With `op_valid`=1, the codes 3'b010, 3'b011, 3'b110 and 3'b111 set `illegal` on the next edge. They leave `out_lanes` and both banks unchanged.
- R7: A load whose segment index is 256/(LANES*4) or more writes nothing, leaves `out_lanes` unchanged and sets `illegal` on the next edge.
- R8: With `op_valid`=0, nothing is written, `out_lanes` holds and `illegal` is 0 after the next edge.
- R9: A lookup issued in the cycle right after a load returns the newly loaded bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request qualifier |
| fn | input | 3 | Function code; bit 0 selects the bank |
| seg_idx | input | SEG_W | Segment index for loads |
| idx_lanes | input | LANES*8 | Byte lanes used as lookup addresses |
| word_lanes | input | LANES*32 | Word lanes holding load data |
| out_lanes | output | LANES*8 | Registered lookup results |
| illegal | output | 1 | Registered refusal flag |

## Verification
Lookups are tried with every lane at address 0, every lane at 255, and a different address on each lane. Together these show whether addressing is per lane and whether the end entries are reached. Full sweeps of both banks after loads tell a correct segment base and byte order apart from a shifted, wrapped or byte-swapped one. They also tell independent banks apart from aliased ones.

Out-of-range segments, reserved codes and idle cycles are each followed by a sweep to show that no entry moved. A lookup placed right after a load separates immediate visibility from stale reads. A long seeded random mix of all codes covers interleavings that the directed cases miss.

// File: rtl/dual_bank_lane_lut.sv
module dual_bank_lane_lut #(
  parameter int LANES = 8,
  parameter int SEG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            fn,
  input  logic [SEG_W-1:0]      seg_idx,
  input  logic [LANES*8-1:0]    idx_lanes,
  input  logic [LANES*32-1:0]   word_lanes,
  output logic [LANES*8-1:0]    out_lanes,
  output logic                  illegal
);
  localparam int SEG_BYTES = LANES * 4;
  localparam int NUM_SEG   = 256 / SEG_BYTES;

  logic [7:0] bank_a [256];
  logic [7:0] bank_b [256];

  logic seg_ok, is_lookup, is_load, do_load, refuse;
  logic [7:0] base;
  logic [LANES*8-1:0] rd_lanes;

  assign seg_ok    = int'(seg_idx) < NUM_SEG;
  assign is_lookup = op_valid && fn[2:1] == 2'b00;
  assign is_load   = op_valid && fn[2:1] == 2'b10;
  assign do_load   = is_load && seg_ok;
  assign refuse    = op_valid && (fn[1] || (is_load && !seg_ok));
  assign base      = 8'(int'(seg_idx) * SEG_BYTES);

  always_ff @(posedge clk) begin
    if (do_load) begin
      for (int b = 0; b < SEG_BYTES; b++) begin
        if (fn[0]) bank_b[8'(b) + base] <= word_lanes[b*8 +: 8];
        else       bank_a[8'(b) + base] <= word_lanes[b*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      rd_lanes[l*8 +: 8] = fn[0] ? bank_b[idx_lanes[l*8 +: 8]] : bank_a[idx_lanes[l*8 +: 8]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lanes <= '0;
      illegal   <= 1'b0;
    end else begin
      illegal <= refuse;
      if (is_lookup) out_lanes <= rd_lanes;
    end
  end
endmodule

// File: rtl/dual_bank_lane_lut_chk.sv
module dual_bank_lane_lut_chk #(
  parameter int LANES = 8,
  parameter int SEG_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [2:0]         fn,
  input logic [SEG_W-1:0]   seg_idx,
  input logic [LANES*8-1:0] out_lanes,
  input logic               illegal
);
  localparam int NUM_SEG = 256 / (LANES * 4);

  // R2
  lookup_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fn[2:1] == 2'b00) |=> !illegal);

  // R5
  load_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fn[2:1] == 2'b10) |=> $stable(out_lanes));

  // R6
  reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fn[1]) |=> (illegal && $stable(out_lanes)));

  // R7
  bad_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fn[2:1] == 2'b10 && int'(seg_idx) >= NUM_SEG) |=> illegal);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!illegal && $stable(out_lanes)));
endmodule

bind dual_bank_lane_lut dual_bank_lane_lut_chk #(.LANES(LANES), .SEG_W(SEG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fn(fn), .seg_idx(seg_idx),
  .out_lanes(out_lanes), .illegal(illegal)
);

// File: tb/dual_bank_lane_lut_tb_top.sv
`timescale 1ns/1ps
module dual_bank_lane_lut_tb_top;
  localparam int L   = 8;
  localparam int SW  = 4;
  localparam int SEGB = L * 4;
  localparam int NSEG = 256 / SEGB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] fn = '0;
  logic [SW-1:0] seg_idx = '0;
  logic [L*8-1:0] idx_lanes = '0;
  logic [L*32-1:0] word_lanes = '0;
  logic [L*8-1:0] out_lanes;
  logic illegal;

  always #10 clk = ~clk;

  dual_bank_lane_lut #(.LANES(L), .SEG_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fn(fn), .seg_idx(seg_idx),
    .idx_lanes(idx_lanes), .word_lanes(word_lanes), .out_lanes(out_lanes), .illegal(illegal)
  );

  logic [7:0] mdl [2][256];
  logic [L*8-1:0] exp_out = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [L*32-1:0] rnd_words();
    logic [L*32-1:0] w;
    for (int i = 0; i < L; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [L*8-1:0] rnd_bytes();
    logic [L*8-1:0] b;
    for (int i = 0; i < L; i++) b[i*8 +: 8] = 8'($urandom);
    return b;
  endfunction

  task automatic cmp_out(input string tag, input logic [L*8-1:0] e);
    n_cmp++;
    if (out_lanes !== e) begin
      n_bad++;
      $display("FAIL %s out_lanes actual=%h expected=%h", tag, out_lanes, e);
    end
  endtask

  task automatic cmp_ill(input string tag, input logic e);
    n_cmp++;
    if (illegal !== e) begin
      n_bad++;
      $display("FAIL %s illegal actual=%b expected=%b", tag, illegal, e);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input logic v, input logic [2:0] f, input int s,
                      input logic [L*8-1:0] b, input logic [L*32-1:0] w, input string tag);
    logic e_ill;
    op_valid = v; fn = f; seg_idx = SW'(s); idx_lanes = b; word_lanes = w;
    e_ill = 1'b0;
    if (v) begin
      if (f[2:1] == 2'b00) begin
        for (int i = 0; i < L; i++) exp_out[i*8 +: 8] = mdl[f[0]][b[i*8 +: 8]];
      end else if (f[2:1] == 2'b10) begin
        if (s < NSEG) begin
          for (int k = 0; k < SEGB; k++) mdl[f[0]][s*SEGB + k] = w[k*8 +: 8];
        end else e_ill = 1'b1;
      end else e_ill = 1'b1;
    end
    @(negedge clk);
    cmp_out(tag, exp_out);
    cmp_ill(tag, e_ill);
    op_valid = 1'b0;
  endtask

  task automatic sweep(input int bank, input string tag);
    for (int g = 0; g < 256 / L; g++) begin
      logic [L*8-1:0] b;
      for (int i = 0; i < L; i++) b[i*8 +: 8] = 8'(g*L + i);
      step(1'b1, {2'b00, bank[0]}, 0, b, '0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    cmp_out("R1", '0);
    cmp_ill("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < NSEG; s++) step(1'b1, 3'b100, s, '0, rnd_words(), "R4");
    for (int s = 0; s < NSEG; s++) step(1'b1, 3'b101, s, '0, rnd_words(), "R4");
    sweep(0, "R4 R2 bank A");
    sweep(1, "R4 R3 bank B");

    step(1'b1, 3'b000, 0, '0, '0, "R2 all zero");
    step(1'b1, 3'b001, 0, '1, '0, "R3 all 255");
    step(1'b1, 3'b000, 0, 64'h00ff_7f80_0102_fe40, '0, "R2 mixed");
    step(1'b1, 3'b100, 2, '0, rnd_words(), "R5 load holds");

    step(1'b1, 3'b101, 3, '0, rnd_words(), "R9 load");
    step(1'b1, 3'b001, 0, 64'h7f7e_7d7c_6362_6160, '0, "R9 next lookup");
    sweep(0, "R3 A untouched by B loads");

    step(1'b1, 3'b100, 8, '0, rnd_words(), "R7 seg 8");
    step(1'b1, 3'b101, 15, '0, rnd_words(), "R7 seg 15");
    step(1'b1, 3'b010, 0, rnd_bytes(), rnd_words(), "R6 010");
    step(1'b1, 3'b011, 1, rnd_bytes(), rnd_words(), "R6 011");
    step(1'b1, 3'b110, 1, rnd_bytes(), rnd_words(), "R6 110");
    step(1'b1, 3'b111, 2, rnd_bytes(), rnd_words(), "R6 111");
    step(1'b0, 3'b100, 0, rnd_bytes(), rnd_words(), "R8 idle load");
    step(1'b0, 3'b000, 0, rnd_bytes(), rnd_words(), "R8 idle lookup");
    sweep(0, "R7 R6 R8 bank A intact");
    sweep(1, "R7 R6 R8 bank B intact");

    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic [2:0] f;
      int s;
      string tag;
      v = ($urandom % 8) != 0;
      f = 3'($urandom);
      s = $urandom % 10;
      if (!v) tag = "R8 random";
      else if (f[2:1] == 2'b00) tag = f[0] ? "R3 random" : "R2 random";
      else if (f[1]) tag = "R6 random";
      else if (s >= NSEG) tag = "R7 random";
      else tag = "R5 random";
      step(v, f, s, rnd_bytes(), rnd_words(), tag);
    end
    sweep(0, "R4 final A");
    sweep(1, "R4 final B");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule